// File: doc/BRIEF.md
# Single-Channel Peripheral-to-Memory DMA Mover

This block copies one data word from a peripheral register into a data-memory location while the processor goes on with its own work. Software first writes the source and destination addresses into two configuration registers through a small write-only port. When the peripheral raises its service request, the mover asks the processor for the system bus. It waits for the grant, acknowledges the peripheral, reads the word from the source address, and writes it to the destination address. It then withdraws both its bus request and its peripheral acknowledge in the same cycle.

Two four-phase handshakes are interlocked. On the peripheral side the pair is request/acknowledge. On the processor side the pair is bus-request/bus-grant. The mover drives the bus only while the grant is held. After it releases, it waits until both the peripheral request and the grant have returned low before it accepts new work, so a stale request cannot start a second move.

The bus master port has a ready input for back-pressure. A read or a write completes on a clock edge where its strobe, the grant and `bus_rdy` are all high. While `bus_rdy` is low, the strobe, the address and the write data hold their values. A single-cycle completion pulse lets software count finished moves.

Top module: `dma_mover`

## Requirements
- R1: While `rst_n` is low, and after it is released, every output is low or zero and the mover is idle.
- R2: A high `per_req` seen in idle makes `bus_req` high on the next cycle. `per_ack` stays low until the grant has been seen.
- R3: While `bus_gnt` is low, `bus_rd`, `bus_wr`, `bus_addr` and `bus_wdata` are all zero.
- R4: After the grant, the mover raises `per_ack` and `bus_rd` with the source address on `bus_addr`. It holds them until a cycle with `bus_rdy` high, and captures `bus_rdata` on that edge.
- R5: After the read, the mover drives `bus_wr` with the destination address and the captured word on `bus_wdata`. It holds them until a cycle with `bus_rdy` high.
- R6: In the cycle after the write completes, `bus_req` and `per_ack` fall together and `xfer_done` is high for exactly one cycle.
- R7: After a move, the mover returns to idle only once both `per_req` and `bus_gnt` are low. A request that stays high does not start a new move.
- R8: A configuration write (`cfg_we` high) loads `cfg_wdata` into the source register when `cfg_sel` is 0, or into the destination register when it is 1. The write takes effect only while idle and is ignored at any other time.
- R9: If the grant is withdrawn during a read or a write, the mover makes no progress and releases the bus. It resumes the same bus cycle when the grant returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 1 | 0 selects the source register, 1 the destination register |
| cfg_wdata | input | ADDR_W | Address value to store |
| per_req | input | 1 | Service request from the peripheral |
| per_ack | output | 1 | Acknowledge to the peripheral |
| bus_req | output | 1 | Bus request to the processor |
| bus_gnt | input | 1 | Bus grant from the processor |
| bus_addr | output | ADDR_W | Bus address, zero unless driving a cycle |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_rdata | input | DATA_W | Read data from the bus |
| bus_wdata | output | DATA_W | Write data to the bus |
| bus_rdy | input | 1 | Bus cycle completes when high with a strobe |
| xfer_done | output | 1 | One-cycle pulse per completed move |

## Verification
The bench builds the mover with its defaults: 16-bit addresses and 8-bit data. With these widths the source 0x8000 uses the top address bit and the destination 0x0001 uses the bottom one, so a swapped or truncated address is visible at once. The 8-bit data patterns 0x5A, 0xC3, 0x3C and 0x96 toggle every bit of the holding register. The cycle table covers grant withdrawal, `bus_rdy` stalls on both the read and the write, and a request held high past completion. Directed steps check a configuration write blocked mid-move, a configuration write accepted in idle, and a reset applied during a write.

// File: rtl/dma_mover_pkg.sv
package dma_mover_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_REQ_BUS   = 3'd1,
    ST_READ      = 3'd2,
    ST_WRITE     = 3'd3,
    ST_RELEASE   = 3'd4,
    ST_WAIT_DONE = 3'd5
  } xfer_st_e;

  localparam logic SEL_SRC = 1'b0;
  localparam logic SEL_DST = 1'b1;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_mover_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SRC_INIT = '0,
  parameter logic [ADDR_W-1:0] DST_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sel,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              allow,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o
);

  logic take;
  assign take = wr_en && allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_o <= SRC_INIT;
      dst_o <= DST_INIT;
    end else if (take) begin
      if (sel == SEL_SRC) src_o <= wdata;
      else                dst_o <= wdata;
    end
  end

  // R8: registers frozen while a move is running
  a_r8_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !allow |=> ($stable(src_o) && $stable(dst_o)));

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_mover_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic per_req,
  input  logic bus_gnt,
  input  logic bus_rdy,
  output logic idle_o,
  output logic breq_o,
  output logic ack_o,
  output logic rd_phase_o,
  output logic wr_phase_o,
  output logic capture_o,
  output logic done_o
);

  xfer_st_e st_q, st_d;
  logic     step;

  assign step = bus_gnt && bus_rdy;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:      if (per_req) st_d = ST_REQ_BUS;
      ST_REQ_BUS:   if (bus_gnt) st_d = ST_READ;
      ST_READ:      if (step)    st_d = ST_WRITE;
      ST_WRITE:     if (step)    st_d = ST_RELEASE;
      ST_RELEASE:                st_d = ST_WAIT_DONE;
      ST_WAIT_DONE: if (!per_req && !bus_gnt) st_d = ST_IDLE;
      default:                   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign idle_o     = (st_q == ST_IDLE);
  assign breq_o     = (st_q == ST_REQ_BUS) || (st_q == ST_READ) || (st_q == ST_WRITE);
  assign ack_o      = (st_q == ST_READ) || (st_q == ST_WRITE);
  assign rd_phase_o = (st_q == ST_READ);
  assign wr_phase_o = (st_q == ST_WRITE);
  assign capture_o  = rd_phase_o && step;
  assign done_o     = (st_q == ST_RELEASE);

  // R2: an idle request produces a bus request next cycle
  a_r2_req_to_breq: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_o && per_req) |=> breq_o);

  // R6: completion pulse lasts one cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: no return to idle while either handshake line is still high
  a_r7_wait_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_WAIT_DONE) && (per_req || bus_gnt)) |=> (st_q == ST_WAIT_DONE));

  // R9: no progress through a read without the grant
  a_r9_read_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_phase_o && !bus_gnt) |=> rd_phase_o);

endmodule

// File: rtl/dma_bus_port.sv
module dma_bus_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gnt,
  input  logic              rd_phase,
  input  logic              wr_phase,
  input  logic              capture,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] wdata_o
);

  logic [DATA_W-1:0] hold_q;
  logic              drv_rd, drv_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (capture) hold_q <= rdata;
  end

  assign drv_rd = gnt && rd_phase;
  assign drv_wr = gnt && wr_phase;

  always_comb begin
    addr_o = '0;
    if (drv_rd)      addr_o = src;
    else if (drv_wr) addr_o = dst;
  end

  assign rd_o    = drv_rd;
  assign wr_o    = drv_wr;
  assign wdata_o = drv_wr ? hold_q : '0;

  // R4: the captured word does not change while writing
  a_r4_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_phase && !capture) |=> $stable(hold_q));

endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_mover_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              per_req,
  output logic              per_ack,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rdy,
  output logic              xfer_done
);

  logic              idle, rd_phase, wr_phase, capture;
  logic [ADDR_W-1:0] src_addr, dst_addr;

  dma_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_we),
    .sel   (cfg_sel),
    .wdata (cfg_wdata),
    .allow (idle),
    .src_o (src_addr),
    .dst_o (dst_addr)
  );

  dma_xfer_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .per_req    (per_req),
    .bus_gnt    (bus_gnt),
    .bus_rdy    (bus_rdy),
    .idle_o     (idle),
    .breq_o     (bus_req),
    .ack_o      (per_ack),
    .rd_phase_o (rd_phase),
    .wr_phase_o (wr_phase),
    .capture_o  (capture),
    .done_o     (xfer_done)
  );

  dma_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .gnt      (bus_gnt),
    .rd_phase (rd_phase),
    .wr_phase (wr_phase),
    .capture  (capture),
    .src      (src_addr),
    .dst      (dst_addr),
    .rdata    (bus_rdata),
    .addr_o   (bus_addr),
    .rd_o     (bus_rd),
    .wr_o     (bus_wr),
    .wdata_o  (bus_wdata)
  );

  // R3: bus quiet whenever the grant is absent
  a_r3_quiet_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_gnt |-> (!bus_rd && !bus_wr && bus_addr == '0 && bus_wdata == '0));

  // R4: peripheral acknowledge only inside an open bus request
  a_r4_ack_in_req: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |-> bus_req);

  // R5: a stalled write stays on the bus unless the grant goes away
  a_r5_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rdy) |=> (bus_wr || !bus_gnt));

  // R6: both handshakes close together with the done pulse
  a_r6_close_together: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> ($fell(per_ack) && xfer_done));

endmodule

// File: tb/test_dma_mover.sv
`timescale 1ns/1ps
module test_dma_mover;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        per_req = 1'b0, bus_gnt = 1'b0, bus_rdy = 1'b0;
  logic [7:0]  bus_rdata = '0;
  logic        per_ack, bus_req, bus_rd, bus_wr, xfer_done;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dma_mover i_dma_mover (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .per_req(per_req), .per_ack(per_ack),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .bus_wdata(bus_wdata), .bus_rdy(bus_rdy), .xfer_done(xfer_done)
  );

  typedef struct packed {
    logic       req, gnt, rdy;
    logic [7:0] rdata;
    logic       breq, ack, rd, wr;
    logic [15:0] addr;
    logic [7:0] wdata;
    logic       done;
  } vec_t;

  // Cycle table; source 0x8000, destination 0x0001 programmed beforehand.
  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0,16'h0000,8'h00,1'b0}, // idle quiet
    '{1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0,16'h0000,8'h00,1'b0}, // R2 request seen
    '{1'b1,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,1'b0,16'h0000,8'h00,1'b0}, // R2 breq, no ack
    '{1'b1,1'b1,1'b0,8'h00, 1'b1,1'b0,1'b0,1'b0,16'h0000,8'h00,1'b0}, // grant arrives
    '{1'b1,1'b1,1'b0,8'h11, 1'b1,1'b1,1'b1,1'b0,16'h8000,8'h00,1'b0}, // R4 read stalled
    '{1'b1,1'b1,1'b1,8'h5A, 1'b1,1'b1,1'b1,1'b0,16'h8000,8'h00,1'b0}, // R4 read done
    '{1'b1,1'b1,1'b1,8'h00, 1'b1,1'b1,1'b0,1'b1,16'h0001,8'h5A,1'b0}, // R5 write
    '{1'b1,1'b1,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0,16'h0000,8'h00,1'b1}, // R6 release
    '{1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0,16'h0000,8'h00,1'b0}, // R7 grant still high
    '{1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0,16'h0000,8'h00,1'b0}, // R7 both low
    '{1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0,16'h0000,8'h00,1'b0}, // idle again
    '{1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0,16'h0000,8'h00,1'b0}, // second request
    '{1'b1,1'b1,1'b0,8'h00, 1'b1,1'b0,1'b0,1'b0,16'h0000,8'h00,1'b0}, // grant at once
    '{1'b1,1'b0,1'b1,8'h77, 1'b1,1'b1,1'b0,1'b0,16'h0000,8'h00,1'b0}, // R9 R3 grant dropped
    '{1'b1,1'b1,1'b1,8'hC3, 1'b1,1'b1,1'b1,1'b0,16'h8000,8'h00,1'b0}, // R9 resume read
    '{1'b1,1'b1,1'b0,8'h00, 1'b1,1'b1,1'b0,1'b1,16'h0001,8'hC3,1'b0}, // R5 write stalled
    '{1'b1,1'b1,1'b1,8'h00, 1'b1,1'b1,1'b0,1'b1,16'h0001,8'hC3,1'b0}, // R5 write done
    '{1'b1,1'b1,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0,16'h0000,8'h00,1'b1}, // R6 release
    '{1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0,16'h0000,8'h00,1'b0}, // R7 stale request
    '{1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0,16'h0000,8'h00,1'b0}, // R7 still no restart
    '{1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0,16'h0000,8'h00,1'b0}, // R7 request gone
    '{1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0,16'h0000,8'h00,1'b0}  // idle
  };

  function automatic logic [28:0] outs();
    return {bus_req, per_ack, bus_rd, bus_wr, bus_addr, bus_wdata, xfer_done};
  endfunction

  task automatic check(input logic [28:0] act, input logic [28:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic req, input logic gnt, input logic rdy, input logic [7:0] rd,
                     input logic we, input logic sel, input logic [15:0] cd);
    @(negedge clk);
    per_req = req; bus_gnt = gnt; bus_rdy = rdy; bus_rdata = rd;
    cfg_we = we; cfg_sel = sel; cfg_wdata = cd;
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: outputs quiet under reset
    repeat (2) @(negedge clk);
    #1 check(outs(), '0, "R1 during reset");
    rst_n = 1'b1;
    cyc(0,0,0,8'h00, 1'b0,1'b0,16'h0);
    check(outs(), '0, "R1 after reset");

    // R8: program addresses while idle
    cyc(0,0,0,8'h00, 1'b1,1'b0,16'h8000);
    cyc(0,0,0,8'h00, 1'b1,1'b1,16'h0001);

    for (int i = 0; i < NV; i++) begin
      cyc(TBL[i].req, TBL[i].gnt, TBL[i].rdy, TBL[i].rdata, 1'b0, 1'b0, 16'h0);
      check(outs(), {TBL[i].breq, TBL[i].ack, TBL[i].rd, TBL[i].wr, TBL[i].addr,
                     TBL[i].wdata, TBL[i].done},
            $sformatf("R2/R3/R4/R5/R6/R7/R9 row %0d", i));
    end

    // R8: write during a move is ignored
    cyc(1,0,1,8'h00, 1'b0,1'b0,16'h0);            // idle -> bus request
    cyc(1,0,1,8'h00, 1'b1,1'b0,16'h1234);         // blocked write
    cyc(1,1,1,8'h00, 1'b0,1'b0,16'h0);            // grant
    cyc(1,1,1,8'h3C, 1'b0,1'b0,16'h0);            // read
    check({bus_rd, bus_addr}, {1'b1, 16'h8000}, "R8 blocked write kept source");
    cyc(1,1,1,8'h00, 1'b0,1'b0,16'h0);            // write
    check({bus_wr, bus_addr, bus_wdata}, {1'b1, 16'h0001, 8'h3C}, "R5 write of 0x3C");
    cyc(0,0,0,8'h00, 1'b0,1'b0,16'h0);            // release
    check({bus_req, per_ack, xfer_done}, 3'b001, "R6 release together");
    cyc(0,0,0,8'h00, 1'b0,1'b0,16'h0);            // wait -> idle

    // R8: write in idle is taken
    cyc(0,0,0,8'h00, 1'b1,1'b0,16'h1234);
    cyc(1,0,1,8'h00, 1'b0,1'b0,16'h0);
    cyc(1,1,1,8'h00, 1'b0,1'b0,16'h0);
    cyc(1,1,1,8'h96, 1'b0,1'b0,16'h0);
    check({bus_rd, bus_addr}, {1'b1, 16'h1234}, "R8 idle write took effect");
    cyc(1,1,0,8'h00, 1'b0,1'b0,16'h0);            // write stalled
    check({bus_wr, bus_wdata}, {1'b1, 8'h96}, "R5 stalled write of 0x96");

    // R1: reset in the middle of a write
    rst_n = 1'b0;
    #1 check(outs(), '0, "R1 reset mid-move");
    @(negedge clk);
    per_req = 1'b0; bus_gnt = 1'b0; bus_rdy = 1'b0;
    rst_n = 1'b1;
    cyc(0,0,0,8'h00, 1'b0,1'b0,16'h0);
    check(outs(), '0, "R1 idle after mid-move reset");
    cyc(1,1,1,8'h00, 1'b0,1'b0,16'h0);
    check(outs(), '0, "R2 no bus request in the request cycle");
    cyc(1,1,1,8'h00, 1'b0,1'b0,16'h0);
    check({bus_req, per_ack}, 2'b10, "R2 request after reset");

    finish_run();
  end

endmodule